// File: doc/BRIEF.md
# Rank Refresh and Power-State Sequencer

This block runs the auto-refresh of one DRAM rank and keeps a record of the rank's power state. A free-running interval timer raises a refresh demand once per refresh interval. Once the demand is taken, the rank is withdrawn from scheduling. The sequencer then waits until the controller reports no accesses still in flight to the rank. It requests a precharge of all banks, waits out the row-precharge time, and then requests a refresh command. That command holds the rank for the refresh-cycle time, after which the rank becomes available again.

Alongside the refresh machine, a second machine follows the rank's power condition. It tracks whether banks are open, whether the controller has requested power-down, and whether a refresh is running. When the last bank closes, the move back to idle is deferred for a short settle window. If a bank opens again inside that window, the pending move is cancelled. The controller uses `rank_avail` to gate its own command selection, and it turns the two one-cycle request strobes into DRAM commands.

Top module: `rank_refresh_seq`

## Requirements
- R1: After reset, `rfsh_state` is 0, `pwr_state` is 0, `rank_avail` is 1, and neither request strobe is high.
- R2: The interval timer expires at the T_REFI-th clock edge after reset release, and every T_REFI edges after that. When the refresh machine is idle, `rfsh_state` moves to drain (code 1) one edge after expiry, so it first reads 1 after edge T_REFI+1.
- R3: In drain, the state holds for as long as `inflight` is sampled nonzero. On the first edge that samples `inflight` as zero, it moves to the precharge phase (code 2).
- R4: `pre_all_req` is high for exactly the first cycle of the precharge phase. The precharge phase lasts T_RP cycles. `refresh_req` is high for exactly the first cycle of the run phase (code 3), and no refresh request occurs without a precharge request before it.
- R5: The run phase lasts T_RFC cycles, and then the refresh state returns to idle (code 0).
- R6: `rank_avail` is 1 exactly when the refresh state is idle, so it is 0 from drain through run.
- R7: The interval timer keeps counting during drain, precharge and run. A refresh delayed by a long drain does not shift the next expiry.
- R8: With the power state idle (0), a nonzero `open_banks` moves it to active (code 3) on the next edge.
- R9: Active returns to idle only after `open_banks` has been sampled zero on T_SETTLE consecutive edges. A nonzero sample inside that window cancels the pending move and restarts the window.
- R10: With power-down enabled, `pdn_req` moves idle to precharge power-down (code 2) and active to active power-down (code 4) on the next edge. Deasserting it returns the state to idle or active, respectively, on the next edge.
- R11: The power state shows refresh (code 1) from one cycle after the refresh state enters run until one cycle after it leaves run, starting from any power state, and then shows idle.
- R12: At most one of `pre_all_req` and `refresh_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_banks | input | $clog2(NUM_BANKS+1) | Number of banks currently open in the rank |
| inflight | input | INF_W | Accesses issued to the rank and not yet completed |
| pdn_req | input | 1 | Controller asks for power-down |
| pre_all_req | output | 1 | One-cycle request to precharge all banks |
| refresh_req | output | 1 | One-cycle request to issue the refresh command |
| rank_avail | output | 1 | Rank may be scheduled |
| rfsh_state | output | 2 | Refresh phase: 0 idle, 1 drain, 2 precharge, 3 run |
| pwr_state | output | 3 | Power state: 0 idle, 1 refresh, 2 precharge power-down, 3 active, 4 active power-down |

## Verification
The refresh flow is run three times. The first run has no traffic and sets the baseline edge counts for each phase. The second run has accesses in flight past the expiry, which separates waiting on the drain from moving on at a fixed time. The third run starts on schedule even though the second was late, which shows that the timer is not reloaded when a refresh completes. On the power side, the tests bring banks open, closed, and open again inside the settle window, which separates cancellation of a pending idle move from a plain delay. Power-down is requested from both the idle and the active state, and a refresh is started while the rank is in power-down.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   typedef enum logic [1:0] {
      RF_IDLE  = 2'd0,
      RF_DRAIN = 2'd1,
      RF_PRE   = 2'd2,
      RF_RUN   = 2'd3
   } rfsh_e;

   typedef enum logic [2:0] {
      PW_IDLE    = 3'd0,
      PW_REF     = 3'd1,
      PW_PRE_PDN = 3'd2,
      PW_ACT     = 3'd3,
      PW_ACT_PDN = 3'd4
   } pwr_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int T_REFI = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic due
);
   localparam int CW = $clog2(T_REFI);
   localparam logic [CW-1:0] LAST = CW'(T_REFI - 1);

   logic [CW-1:0] cnt;

   // free running: never reloaded by the refresh flow
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign due = (cnt == LAST);
endmodule

// File: rtl/rfsh_phase_fsm.sv
module rfsh_phase_fsm
   import rfsh_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_RFC = 10,
   parameter int INF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             due,
   input  logic [INF_W-1:0] inflight,
   output rfsh_e            state,
   output logic             pre_all,
   output logic             ref_cmd
);
   localparam int TMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 1);
   localparam logic [TW-1:0] RFC_LD = TW'(T_RFC - 1);

   rfsh_e         nxt;
   logic          pending;
   logic [TW-1:0] tmr;

   always_comb begin
      nxt = state;
      unique case (state)
         RF_IDLE:  if (pending)            nxt = RF_DRAIN;
         RF_DRAIN: if (inflight == '0)     nxt = RF_PRE;
         RF_PRE:   if (tmr == '0)          nxt = RF_RUN;
         RF_RUN:   if (tmr == '0)          nxt = RF_IDLE;
         default:                          nxt = RF_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= RF_IDLE;
         pending <= 1'b0;
         tmr     <= '0;
         pre_all <= 1'b0;
         ref_cmd <= 1'b0;
      end else begin
         state   <= nxt;
         pre_all <= (state == RF_DRAIN) && (nxt == RF_PRE);
         ref_cmd <= (state == RF_PRE) && (nxt == RF_RUN);
         if (due)
            pending <= 1'b1;
         else if (state == RF_IDLE && pending)
            pending <= 1'b0;
         if (nxt == RF_PRE && state != RF_PRE)
            tmr <= RP_LD;
         else if (nxt == RF_RUN && state != RF_RUN)
            tmr <= RFC_LD;
         else if (tmr != '0)
            tmr <= tmr - 1'b1;
      end
   end
endmodule

// File: rtl/rank_power_fsm.sv
module rank_power_fsm
   import rfsh_pkg::*;
#(
   parameter int OB_W     = 4,
   parameter int T_SETTLE = 4,
   parameter bit PDN_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OB_W-1:0] open_banks,
   input  logic            pdn_req,
   input  logic            rfsh_run,
   output pwr_e            state
);
   localparam int SW = $clog2(T_SETTLE + 1);
   localparam logic [SW-1:0] S_LAST = SW'(T_SETTLE - 1);

   logic          pdn_ok;
   logic          any_open;
   logic [SW-1:0] settle;
   pwr_e          nxt;

   generate
      if (PDN_EN) begin : g_pdn
         assign pdn_ok = pdn_req;
      end else begin : g_nopdn
         assign pdn_ok = pdn_req & 1'b0;
      end
   endgenerate

   assign any_open = (open_banks != '0);

   always_comb begin
      nxt = state;
      if (rfsh_run) begin
         nxt = PW_REF;
      end else begin
         unique case (state)
            PW_IDLE:    if (any_open)      nxt = PW_ACT;
                        else if (pdn_ok)   nxt = PW_PRE_PDN;
            PW_REF:                        nxt = PW_IDLE;
            PW_PRE_PDN: if (!pdn_ok)       nxt = PW_IDLE;
            PW_ACT:     if (!any_open) begin
                           if (settle == S_LAST) nxt = PW_IDLE;
                        end else if (pdn_ok) nxt = PW_ACT_PDN;
            PW_ACT_PDN: if (!pdn_ok)       nxt = PW_ACT;
            default:                       nxt = PW_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= PW_IDLE;
         settle <= '0;
      end else begin
         state <= nxt;
         // pending idle move is cancelled by any open bank
         if (state == PW_ACT && !any_open && !rfsh_run && settle != S_LAST)
            settle <= settle + 1'b1;
         else
            settle <= '0;
      end
   end
endmodule

// File: rtl/rank_refresh_seq.sv
module rank_refresh_seq
   import rfsh_pkg::*;
#(
   parameter int T_REFI    = 100,
   parameter int T_RP      = 3,
   parameter int T_RFC     = 10,
   parameter int T_SETTLE  = 4,
   parameter int NUM_BANKS = 8,
   parameter int INF_W     = 4,
   parameter bit PDN_EN    = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [$clog2(NUM_BANKS+1)-1:0] open_banks,
   input  logic [INF_W-1:0]               inflight,
   input  logic                           pdn_req,
   output logic                           pre_all_req,
   output logic                           refresh_req,
   output logic                           rank_avail,
   output logic [1:0]                     rfsh_state,
   output logic [2:0]                     pwr_state
);
   localparam int OB_W = $clog2(NUM_BANKS + 1);

   generate
      if (T_RP < 1 || T_RFC < 1 || T_SETTLE < 1) begin : g_bad_time
         $error("timing parameters must be at least 1");
      end
      if (T_REFI <= T_RP + T_RFC + 2) begin : g_bad_refi
         $error("T_REFI too short for a refresh sequence");
      end
      if (NUM_BANKS < 1 || INF_W < 1) begin : g_bad_width
         $error("bank count and in-flight width must be positive");
      end
   endgenerate

   logic  due;
   rfsh_e rf_st;
   pwr_e  pw_st;

   rfsh_interval_timer #(.T_REFI(T_REFI)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .due   (due)
   );

   rfsh_phase_fsm #(.T_RP(T_RP), .T_RFC(T_RFC), .INF_W(INF_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .due      (due),
      .inflight (inflight),
      .state    (rf_st),
      .pre_all  (pre_all_req),
      .ref_cmd  (refresh_req)
   );

   rank_power_fsm #(.OB_W(OB_W), .T_SETTLE(T_SETTLE), .PDN_EN(PDN_EN)) u_power (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_banks (open_banks),
      .pdn_req    (pdn_req),
      .rfsh_run   (rf_st == RF_RUN),
      .state      (pw_st)
   );

   assign rank_avail = (rf_st == RF_IDLE);
   assign rfsh_state = rf_st;
   assign pwr_state  = pw_st;
endmodule

// File: rtl/rank_refresh_seq_chk.sv
module rank_refresh_seq_chk #(
   parameter int OB_W  = 4,
   parameter int INF_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OB_W-1:0]  open_banks,
   input logic [INF_W-1:0] inflight,
   input logic             pre_all_req,
   input logic             refresh_req,
   input logic             rank_avail,
   input logic [1:0]       rfsh_state,
   input logic [2:0]       pwr_state
);
   p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_state == 2'd1 && inflight != '0) |=> rfsh_state == 2'd1);

   p_pre_after_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all_req |-> ($past(rfsh_state) == 2'd1 && $past(inflight) == '0));

   p_pre_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all_req |=> !pre_all_req);

   p_ref_after_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> $past(rfsh_state) == 2'd2);

   p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_all_req || refresh_req) |-> !rank_avail);

   p_act_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd3 && open_banks != '0) |=> pwr_state != 3'd0);

   p_ref_power_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_state == 2'd3 && $past(rfsh_state) == 2'd3) |-> pwr_state == 3'd1);

   p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pre_all_req, refresh_req}));
endmodule

bind rank_refresh_seq rank_refresh_seq_chk #(.OB_W(OB_W), .INF_W(INF_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .open_banks  (open_banks),
   .inflight    (inflight),
   .pre_all_req (pre_all_req),
   .refresh_req (refresh_req),
   .rank_avail  (rank_avail),
   .rfsh_state  (rfsh_state),
   .pwr_state   (pwr_state)
);

// File: tb/rank_refresh_seq_test.sv
module rank_refresh_seq_test;
   localparam int T_REFI = 100;
   localparam int T_RP = 3;
   localparam int T_RFC = 10;
   localparam int T_SETTLE = 4;
   localparam int NB = 8;
   localparam int OBW = $clog2(NB + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [OBW-1:0] open_banks = '0;
   logic [3:0] inflight = '0;
   logic pdn_req = 1'b0;
   logic pre_all_req, refresh_req, rank_avail;
   logic [1:0] rfsh_state;
   logic [2:0] pwr_state;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   typedef struct { int kind; int at; } ev_t;
   ev_t exp_q[$];

   always #10 clk = ~clk;

   rank_refresh_seq #(.T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC),
      .T_SETTLE(T_SETTLE), .NUM_BANKS(NB), .INF_W(4), .PDN_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .open_banks(open_banks), .inflight(inflight),
      .pdn_req(pdn_req), .pre_all_req(pre_all_req), .refresh_req(refresh_req),
      .rank_avail(rank_avail), .rfsh_state(rfsh_state), .pwr_state(pwr_state));

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   // driver side of the scoreboard: kind 0 = precharge-all, 1 = refresh
   task automatic expect_ev(input int kind, input int at);
      ev_t e;
      e.kind = kind;
      e.at = at;
      exp_q.push_back(e);
   endtask

   task automatic take_ev(input int kind);
      ev_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, "R4 unexpected strobe", kind, -1);
      end else begin
         e = exp_q.pop_front();
         check(e.kind == kind, "R4 strobe kind", kind, e.kind);
         check(e.at == cyc, "R4 strobe cycle", cyc, e.at);
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (pre_all_req && refresh_req)
            check(1'b0, "R12 both strobes", 2, 1);
         if (pre_all_req) take_ev(0);
         if (refresh_req) take_ev(1);
      end
   end

   task automatic at_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   initial begin
      expect_ev(0, 102); expect_ev(1, 105);
      expect_ev(0, 211); expect_ev(1, 214);
      expect_ev(0, 302); expect_ev(1, 305);

      repeat (3) @(negedge clk);
      check(rfsh_state == 2'd0, "R1 refresh state", rfsh_state, 0);
      check(pwr_state == 3'd0, "R1 power state", pwr_state, 0);
      check(rank_avail == 1'b1, "R1 avail", rank_avail, 1);
      check(!pre_all_req && !refresh_req, "R1 strobes", pre_all_req | refresh_req, 0);
      rst_n = 1'b1;

      // power machine
      at_cyc(20); open_banks = 2;
      at_cyc(21); check(pwr_state == 3'd3, "R8 idle to act", pwr_state, 3);
      at_cyc(25); pdn_req = 1'b1;
      at_cyc(26); check(pwr_state == 3'd4, "R10 act pdn", pwr_state, 4);
      at_cyc(28); pdn_req = 1'b0;
      at_cyc(29); check(pwr_state == 3'd3, "R10 act pdn exit", pwr_state, 3);
      at_cyc(30); open_banks = 0;
      at_cyc(32); open_banks = 1;
      at_cyc(34); check(pwr_state == 3'd3, "R9 cancelled idle move", pwr_state, 3);
      at_cyc(35); open_banks = 0;
      at_cyc(38); check(pwr_state == 3'd3, "R9 still settling", pwr_state, 3);
      at_cyc(39); check(pwr_state == 3'd0, "R9 settled to idle", pwr_state, 0);
      at_cyc(45); pdn_req = 1'b1;
      at_cyc(46); check(pwr_state == 3'd2, "R10 pre pdn", pwr_state, 2);
      at_cyc(50); pdn_req = 1'b0;
      at_cyc(51); check(pwr_state == 3'd0, "R10 pre pdn exit", pwr_state, 0);

      // first refresh, no traffic
      at_cyc(100); check(rfsh_state == 2'd0 && rank_avail, "R2 not yet draining", rfsh_state, 0);
      at_cyc(101); check(rfsh_state == 2'd1, "R2 drain entry", rfsh_state, 1);
      check(rank_avail == 1'b0, "R6 blocked in drain", rank_avail, 0);
      at_cyc(104); check(rfsh_state == 2'd2, "R4 precharge length", rfsh_state, 2);
      at_cyc(105); check(rfsh_state == 2'd3, "R4 run entry", rfsh_state, 3);
      at_cyc(106); check(pwr_state == 3'd1, "R11 power refresh", pwr_state, 1);
      at_cyc(114); check(rfsh_state == 2'd3 && !rank_avail, "R5 run length", rfsh_state, 3);
      at_cyc(115); check(rfsh_state == 2'd0 && rank_avail, "R5 back to idle", rfsh_state, 0);
      check(pwr_state == 3'd1, "R11 power lags run exit", pwr_state, 1);
      at_cyc(116); check(pwr_state == 3'd0, "R11 power idle after", pwr_state, 0);

      // second refresh, long drain
      at_cyc(150); inflight = 4'd2;
      at_cyc(201); check(rfsh_state == 2'd1, "R2 second drain", rfsh_state, 1);
      at_cyc(210); check(rfsh_state == 2'd1, "R3 drain held", rfsh_state, 1);
      inflight = 4'd0;
      at_cyc(211); check(rfsh_state == 2'd2, "R3 drain released", rfsh_state, 2);
      at_cyc(224); check(rfsh_state == 2'd0, "R5 second done", rfsh_state, 0);

      // third refresh on schedule, entered from power-down
      at_cyc(290); pdn_req = 1'b1;
      at_cyc(291); check(pwr_state == 3'd2, "R10 pdn before refresh", pwr_state, 2);
      at_cyc(301); check(rfsh_state == 2'd1, "R7 schedule kept", rfsh_state, 1);
      at_cyc(306); check(pwr_state == 3'd1, "R11 refresh from pdn", pwr_state, 1);
      pdn_req = 1'b0;
      at_cyc(316); check(pwr_state == 3'd0, "R11 idle after refresh", pwr_state, 0);

      at_cyc(330);
      check(exp_q.size() == 0, "R4 missing strobes", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 330);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule